// File: doc/BRIEF.md
# SPI Command Guard

This block sits between a register front end and a serial-flash host engine. When software writes a command segment, the block checks it before the engine sees it. The segment carries a byte count, a keep-select flag, a lane speed and a transfer direction, and the chip-select ID is taken at the same moment. The block tests the command against the engine's ready state, the legal speed and direction pairs, and the number of chip selects. A command that passes is pushed to the command queue one cycle later, together with the ID it was written with. A command that fails sets a sticky error flag and is never pushed.

The error flags stay set until they are cleared by writing 1 to them. While any flag is set, new commands are refused. Per-class enables turn the flags into one error interrupt. A second interrupt reports events. Some events are levels: the TX FIFO is below its watermark, or the RX FIFO is above its watermark. Others are edges: the engine goes idle, the engine becomes ready, TX becomes empty, or RX becomes full. Edge events are latched and acknowledged by writing 1.

Encodings used throughout:
- Speed: 0 is single lane, 1 is dual, 2 is quad, 3 is reserved.
- Direction: 0 is dummy, 1 is receive, 2 is transmit, 3 is both.
- Error flag bits: [0] busy, [1] TX overflow, [2] RX underflow, [3] bad command, [4] bad chip-select ID, [5] zero-byte access.
- Event enable bits: [0] idle, [1] ready, [2] TX empty, [3] RX full, [4] TX watermark, [5] RX watermark.
- Latched edge bits: [0] idle, [1] ready, [2] TX empty, [3] RX full.

Top module: `spi_cmd_guard`

## Requirements
- R1: A command write while `ready_i` is low and no error flag is set sets error bit 0 and pushes nothing.
- R2: A command with speed 3, or with direction 3 and a speed other than 0, sets error bit 3 and pushes nothing.
- R3: A command whose chip-select ID is not below NUM_CS sets error bit 4 and pushes nothing. R2 and R3 can set their bits in the same cycle.
- R4: A pulse on `tx_overflow_i` sets error bit 1, a pulse on `rx_underflow_i` sets error bit 2, and a pulse on `access_inval_i` sets error bit 5.
- R5: Error flags stay set until `err_clr_i` is high with a 1 in the flag's position of `err_clr_mask_i`. A flag that is set and cleared in the same cycle ends up set.
- R6: While any error flag is set, a command write is dropped without a push and without changing any flag.
- R7: A command that passes all checks gives `q_push_o` high for exactly one cycle, one cycle after the write. The queue fields carry the length, keep-select, speed, direction and chip-select ID that were present during the write.
- R8: `err_irq_o` is the OR of error bits 4..0 ANDed with their five enables, ORed with bit 5, which has no enable. All five enables reset to 1 and are loaded by `err_en_wr_i`.
- R9: The TX watermark event is active while `tx_level_i` is below the TX watermark, which resets to 0. The RX watermark event is active while `rx_level_i` is above the RX watermark, which resets to 127. `wm_wr_i` loads both watermarks.
- R10: An edge event latches only while its enable is set. The edges are: `active_i` falls, `ready_i` rises, `tx_empty_i` rises, `rx_full_i` rises. An acknowledge with a mask bit of 1 clears the latched bit, and a new edge in the same cycle wins over the acknowledge.
- R11: `evt_irq_o` is the OR of all latched edge bits and the enabled watermark events. It follows level changes combinationally.
- R12: After reset the following are all zero: the push, the error flags, the latched edges, both interrupts, and the event enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command segment write strobe |
| cmd_len_i | input | LEN_W | Segment length field |
| cmd_keep_cs_i | input | 1 | Keep chip select low after the segment |
| cmd_speed_i | input | 2 | Lane speed code |
| cmd_dir_i | input | 2 | Direction code |
| csid_i | input | CSID_W | Chip-select ID captured with the command |
| ready_i | input | 1 | Engine can take a command |
| active_i | input | 1 | Engine is busy with a command |
| tx_overflow_i | input | 1 | TX FIFO overflow pulse |
| rx_underflow_i | input | 1 | Read of empty RX FIFO pulse |
| access_inval_i | input | 1 | Zero-byte data write pulse |
| err_clr_i | input | 1 | Write-1-to-clear strobe for error flags |
| err_clr_mask_i | input | 6 | Error flags to clear |
| err_en_wr_i | input | 1 | Load error enables |
| err_en_wdata_i | input | 5 | New error enables |
| tx_level_i | input | LVL_W | TX FIFO fill level |
| rx_level_i | input | LVL_W | RX FIFO fill level |
| tx_empty_i | input | 1 | TX FIFO empty |
| rx_full_i | input | 1 | RX FIFO full |
| evt_en_wr_i | input | 1 | Load event enables |
| evt_en_wdata_i | input | 6 | New event enables |
| wm_wr_i | input | 1 | Load both watermarks |
| tx_wm_wdata_i | input | LVL_W | New TX watermark |
| rx_wm_wdata_i | input | LVL_W | New RX watermark |
| evt_ack_i | input | 1 | Write-1-to-clear strobe for latched edges |
| evt_ack_mask_i | input | 4 | Latched edges to clear |
| q_push_o | output | 1 | Push to command queue |
| q_len_o | output | LEN_W | Queued length |
| q_keep_cs_o | output | 1 | Queued keep-select flag |
| q_speed_o | output | 2 | Queued speed |
| q_dir_o | output | 2 | Queued direction |
| q_csid_o | output | CSID_W | Queued chip-select ID |
| err_status_o | output | 6 | Sticky error flags |
| err_irq_o | output | 1 | Error interrupt |
| edge_pend_o | output | 4 | Latched edge events |
| evt_irq_o | output | 1 | Event interrupt |

## Verification
Two kinds of same-cycle collision are provoked. In the first, a write-1 clear of an error flag lands on the same edge as the pulse that sets that flag again. In the second, an edge-event acknowledge lands on the cycle where the same edge recurs. In both cases the flag or latched bit is expected to remain set. Each one is also checked by a directed comparison against a literal value. Cycle by cycle, a behavioural model checks that a command arriving while a flag is pending is dropped. It also checks that a bad speed and a bad chip-select ID raise both flags together.

// File: rtl/spi_cmd_guard_pkg.sv
package spi_cmd_guard_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DUAL   = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_RSVD   = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        DIR_DUMMY = 2'd0,
        DIR_RX    = 2'd1,
        DIR_TX    = 2'd2,
        DIR_BOTH  = 2'd3
    } dir_e;

    localparam int ERR_N     = 6;
    localparam int ERR_BUSY  = 0;
    localparam int ERR_OVF   = 1;
    localparam int ERR_UDF   = 2;
    localparam int ERR_CMD   = 3;
    localparam int ERR_CSID  = 4;
    localparam int ERR_ACC   = 5;

    localparam int EDGE_N    = 4;
    localparam int EVT_N     = EDGE_N + 2;
    localparam int EVT_TXWM  = 4;
    localparam int EVT_RXWM  = 5;

endpackage

// File: rtl/spi_cmd_guard_check.sv
module spi_cmd_guard_check
    import spi_cmd_guard_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CSID_W = 8
) (
    input  logic [1:0]        speed_i,
    input  logic [1:0]        dir_i,
    input  logic [CSID_W-1:0] csid_i,
    output logic              bad_cmd_o,
    output logic              bad_csid_o
);
    localparam logic [CSID_W:0] CS_LIMIT = (CSID_W+1)'(NUM_CS);

    always_comb begin
        bad_cmd_o  = (speed_i == SPD_RSVD) ||
                     ((dir_i == DIR_BOTH) && (speed_i != SPD_SINGLE));
        bad_csid_o = ({1'b0, csid_i} >= CS_LIMIT);
    end
endmodule

// File: rtl/spi_cmd_guard_events.sv
module spi_cmd_guard_events
    import spi_cmd_guard_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic              ready_i,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic              evt_en_wr_i,
    input  logic [EVT_N-1:0]  evt_en_wdata_i,
    input  logic              wm_wr_i,
    input  logic [LVL_W-1:0]  tx_wm_wdata_i,
    input  logic [LVL_W-1:0]  rx_wm_wdata_i,
    input  logic              evt_ack_i,
    input  logic [EDGE_N-1:0] evt_ack_mask_i,
    output logic [EDGE_N-1:0] edge_pend_o,
    output logic              evt_irq_o
);
    localparam logic [LVL_W-1:0] RX_WM_RST = LVL_W'(127);

    typedef struct packed {
        logic [EVT_N-1:0]  en;
        logic [LVL_W-1:0]  tx_wm;
        logic [LVL_W-1:0]  rx_wm;
        logic [EDGE_N-1:0] seen;
        logic [EDGE_N-1:0] pend;
    } evt_state_t;

    evt_state_t state_d, state_q;
    logic [EDGE_N-1:0] cur, rise, ack;
    logic tx_low, rx_high;

    always_comb begin
        cur     = {rx_full_i, tx_empty_i, ready_i, ~active_i};
        rise    = cur & ~state_q.seen & state_q.en[EDGE_N-1:0];
        ack     = evt_ack_i ? evt_ack_mask_i : '0;
        state_d = state_q;
        state_d.seen = cur;
        state_d.pend = (state_q.pend & ~ack) | rise;
        if (evt_en_wr_i) state_d.en = evt_en_wdata_i;
        if (wm_wr_i) begin
            state_d.tx_wm = tx_wm_wdata_i;
            state_d.rx_wm = rx_wm_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q       <= '0;
            state_q.rx_wm <= RX_WM_RST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tx_low      = state_q.en[EVT_TXWM] && (tx_level_i < state_q.tx_wm);
        rx_high     = state_q.en[EVT_RXWM] && (rx_level_i > state_q.rx_wm);
        edge_pend_o = state_q.pend;
        evt_irq_o   = (|state_q.pend) | tx_low | rx_high;
    end
endmodule

// File: rtl/spi_cmd_guard.sv
module spi_cmd_guard
    import spi_cmd_guard_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CSID_W = 8,
    parameter int LEN_W  = 9,
    parameter int LVL_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_wr_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic              cmd_keep_cs_i,
    input  logic [1:0]        cmd_speed_i,
    input  logic [1:0]        cmd_dir_i,
    input  logic [CSID_W-1:0] csid_i,
    input  logic              ready_i,
    input  logic              active_i,
    input  logic              tx_overflow_i,
    input  logic              rx_underflow_i,
    input  logic              access_inval_i,
    input  logic              err_clr_i,
    input  logic [5:0]        err_clr_mask_i,
    input  logic              err_en_wr_i,
    input  logic [4:0]        err_en_wdata_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic              evt_en_wr_i,
    input  logic [5:0]        evt_en_wdata_i,
    input  logic              wm_wr_i,
    input  logic [LVL_W-1:0]  tx_wm_wdata_i,
    input  logic [LVL_W-1:0]  rx_wm_wdata_i,
    input  logic              evt_ack_i,
    input  logic [3:0]        evt_ack_mask_i,
    output logic              q_push_o,
    output logic [LEN_W-1:0]  q_len_o,
    output logic              q_keep_cs_o,
    output logic [1:0]        q_speed_o,
    output logic [1:0]        q_dir_o,
    output logic [CSID_W-1:0] q_csid_o,
    output logic [5:0]        err_status_o,
    output logic              err_irq_o,
    output logic [3:0]        edge_pend_o,
    output logic              evt_irq_o
);
    localparam int EN_N = ERR_N - 1;

    typedef struct packed {
        logic [ERR_N-1:0]  status;
        logic [EN_N-1:0]   en;
        logic              push;
        logic [LEN_W-1:0]  len;
        logic              keep_cs;
        logic [1:0]        speed;
        logic [1:0]        dir;
        logic [CSID_W-1:0] csid;
    } guard_state_t;

    guard_state_t state_d, state_q;
    logic bad_cmd, bad_csid;
    logic [ERR_N-1:0] set_v, clr_v;

    spi_cmd_guard_check #(
        .NUM_CS (NUM_CS),
        .CSID_W (CSID_W)
    ) u_check (
        .speed_i    (cmd_speed_i),
        .dir_i      (cmd_dir_i),
        .csid_i     (csid_i),
        .bad_cmd_o  (bad_cmd),
        .bad_csid_o (bad_csid)
    );

    always_comb begin
        state_d      = state_q;
        state_d.push = 1'b0;
        set_v        = '0;
        if (cmd_wr_i && (state_q.status == '0)) begin
            if (!ready_i) begin
                set_v[ERR_BUSY] = 1'b1;
            end else begin
                set_v[ERR_CMD]  = bad_cmd;
                set_v[ERR_CSID] = bad_csid;
                if (!bad_cmd && !bad_csid) begin
                    state_d.push    = 1'b1;
                    state_d.len     = cmd_len_i;
                    state_d.keep_cs = cmd_keep_cs_i;
                    state_d.speed   = cmd_speed_i;
                    state_d.dir     = cmd_dir_i;
                    state_d.csid    = csid_i;
                end
            end
        end
        set_v[ERR_OVF] = tx_overflow_i;
        set_v[ERR_UDF] = rx_underflow_i;
        set_v[ERR_ACC] = access_inval_i;
        clr_v          = err_clr_i ? err_clr_mask_i : '0;
        state_d.status = (state_q.status & ~clr_v) | set_v;
        if (err_en_wr_i) state_d.en = err_en_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= '0;
            state_q.en <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    spi_cmd_guard_events #(
        .LVL_W (LVL_W)
    ) u_events (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .active_i       (active_i),
        .ready_i        (ready_i),
        .tx_empty_i     (tx_empty_i),
        .rx_full_i      (rx_full_i),
        .tx_level_i     (tx_level_i),
        .rx_level_i     (rx_level_i),
        .evt_en_wr_i    (evt_en_wr_i),
        .evt_en_wdata_i (evt_en_wdata_i),
        .wm_wr_i        (wm_wr_i),
        .tx_wm_wdata_i  (tx_wm_wdata_i),
        .rx_wm_wdata_i  (rx_wm_wdata_i),
        .evt_ack_i      (evt_ack_i),
        .evt_ack_mask_i (evt_ack_mask_i),
        .edge_pend_o    (edge_pend_o),
        .evt_irq_o      (evt_irq_o)
    );

    always_comb begin
        q_push_o     = state_q.push;
        q_len_o      = state_q.len;
        q_keep_cs_o  = state_q.keep_cs;
        q_speed_o    = state_q.speed;
        q_dir_o      = state_q.dir;
        q_csid_o     = state_q.csid;
        err_status_o = state_q.status;
        err_irq_o    = (|(state_q.status[EN_N-1:0] & state_q.en)) | state_q.status[ERR_ACC];
    end
endmodule

// File: rtl/spi_cmd_guard_chk.sv
module spi_cmd_guard_chk #(
    parameter int NUM_CS = 4,
    parameter int CSID_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cmd_wr_i,
    input logic              ready_i,
    input logic [1:0]        cmd_speed_i,
    input logic [CSID_W-1:0] csid_i,
    input logic              err_clr_i,
    input logic [5:0]        err_clr_mask_i,
    input logic              q_push_o,
    input logic [1:0]        q_speed_o,
    input logic [CSID_W-1:0] q_csid_o,
    input logic [5:0]        err_status_o,
    input logic              err_irq_o
);
    localparam logic [CSID_W:0] CS_LIMIT = (CSID_W+1)'(NUM_CS);

    p_busy_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && !ready_i && err_status_o == 6'd0) |=> (!q_push_o && err_status_o[0]));

    p_rsvd_speed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && ready_i && err_status_o == 6'd0 && cmd_speed_i == 2'd3)
        |=> (!q_push_o && err_status_o[3]));

    p_bad_csid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && ready_i && err_status_o == 6'd0 && {1'b0, csid_i} >= CS_LIMIT)
        |=> (!q_push_o && err_status_o[4]));

    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((err_status_o & $past(err_status_o & ~({6{err_clr_i}} & err_clr_mask_i)))
                  == $past(err_status_o & ~({6{err_clr_i}} & err_clr_mask_i))));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && err_status_o != 6'd0) |=> !q_push_o);

    p_push_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_push_o |-> ({1'b0, q_csid_o} < CS_LIMIT && q_speed_o != 2'd3));

    p_access_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_status_o[5] |-> err_irq_o);
endmodule

bind spi_cmd_guard spi_cmd_guard_chk #(
    .NUM_CS (NUM_CS),
    .CSID_W (CSID_W)
) u_chk (.*);

// File: tb/spi_cmd_guard_tb.sv
module spi_cmd_guard_tb;
    localparam int NUM_CS = 4;
    localparam int CSID_W = 8;
    localparam int LEN_W  = 9;
    localparam int LVL_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              cmd_wr = 0, keep = 0, ready = 1, active = 0;
    logic [LEN_W-1:0]  len = 0;
    logic [1:0]        speed = 0, dir = 0;
    logic [CSID_W-1:0] csid = 0;
    logic              ovf = 0, udf = 0, acc = 0, eclr = 0, een_wr = 0;
    logic [5:0]        eclr_m = 0;
    logic [4:0]        een_d = 0;
    logic [LVL_W-1:0]  txl = 0, rxl = 0, txwm_d = 0, rxwm_d = 0;
    logic              txe = 0, rxf = 0, ven_wr = 0, wm_wr = 0, ack = 0;
    logic [5:0]        ven_d = 0;
    logic [3:0]        ack_m = 0;

    logic              push, q_keep, e_irq, v_irq;
    logic [LEN_W-1:0]  q_len;
    logic [1:0]        q_spd, q_dir;
    logic [CSID_W-1:0] q_cs;
    logic [5:0]        status;
    logic [3:0]        pend;

    spi_cmd_guard #(.NUM_CS(NUM_CS), .CSID_W(CSID_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_len_i(len),
        .cmd_keep_cs_i(keep), .cmd_speed_i(speed), .cmd_dir_i(dir), .csid_i(csid),
        .ready_i(ready), .active_i(active), .tx_overflow_i(ovf), .rx_underflow_i(udf),
        .access_inval_i(acc), .err_clr_i(eclr), .err_clr_mask_i(eclr_m),
        .err_en_wr_i(een_wr), .err_en_wdata_i(een_d), .tx_level_i(txl), .rx_level_i(rxl),
        .tx_empty_i(txe), .rx_full_i(rxf), .evt_en_wr_i(ven_wr), .evt_en_wdata_i(ven_d),
        .wm_wr_i(wm_wr), .tx_wm_wdata_i(txwm_d), .rx_wm_wdata_i(rxwm_d),
        .evt_ack_i(ack), .evt_ack_mask_i(ack_m),
        .q_push_o(push), .q_len_o(q_len), .q_keep_cs_o(q_keep), .q_speed_o(q_spd),
        .q_dir_o(q_dir), .q_csid_o(q_cs), .err_status_o(status), .err_irq_o(e_irq),
        .edge_pend_o(pend), .evt_irq_o(v_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit [5:0] m_st, m_set, m_clr;
    bit [4:0] m_een;
    bit [5:0] m_ven;
    int       m_txwm, m_rxwm;
    bit [3:0] m_pend, m_new;
    bit       m_pa, m_pr, m_pt, m_pf;
    bit       m_push;
    int       m_len, m_keep, m_spd, m_dir, m_cs;
    bit       m_bad_cmd, m_bad_cs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_een = 5'h1f; m_ven = 0; m_txwm = 0; m_rxwm = 127;
            m_pend = 0; m_pa = 1; m_pr = 0; m_pt = 0; m_pf = 0; m_push = 0;
            m_len = 0; m_keep = 0; m_spd = 0; m_dir = 0; m_cs = 0;
        end else begin
            m_set = 0;
            m_push = 0;
            if (cmd_wr && m_st == 0) begin
                if (!ready) m_set[0] = 1;
                else begin
                    m_bad_cmd = (speed == 3) || (dir == 3 && speed != 0);
                    m_bad_cs  = (int'(csid) >= NUM_CS);
                    if (m_bad_cmd) m_set[3] = 1;
                    if (m_bad_cs)  m_set[4] = 1;
                    if (!m_bad_cmd && !m_bad_cs) begin
                        m_push = 1; m_len = len; m_keep = keep;
                        m_spd = speed; m_dir = dir; m_cs = csid;
                    end
                end
            end
            if (ovf) m_set[1] = 1;
            if (udf) m_set[2] = 1;
            if (acc) m_set[5] = 1;
            m_clr = eclr ? eclr_m : 6'd0;
            m_st = (m_st & ~m_clr) | m_set;
            m_new = 0;
            if (m_ven[0] && m_pa && !active) m_new[0] = 1;
            if (m_ven[1] && !m_pr && ready)  m_new[1] = 1;
            if (m_ven[2] && !m_pt && txe)    m_new[2] = 1;
            if (m_ven[3] && !m_pf && rxf)    m_new[3] = 1;
            if (ack) m_pend = m_pend & ~ack_m;
            m_pend = m_pend | m_new;
            m_pa = active; m_pr = ready; m_pt = txe; m_pf = rxf;
            if (een_wr) m_een = een_d;
            if (ven_wr) m_ven = ven_d;
            if (wm_wr) begin m_txwm = txwm_d; m_rxwm = rxwm_d; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 push", push, m_push);
            if (m_push) begin
                chk("R7 csid", q_cs, m_cs);
                chk("R7 len", q_len, m_len);
                chk("R7 keep", q_keep, m_keep);
                chk("R7 speed", q_spd, m_spd);
                chk("R7 dir", q_dir, m_dir);
            end
            chk("R5 status", status, m_st);
            chk("R8 err_irq", e_irq, int'((|(m_st[4:0] & m_een)) | m_st[5]));
            chk("R10 pend", pend, m_pend);
            chk("R11 evt_irq", v_irq, int'((|m_pend) ||
                (m_ven[4] && int'(txl) < m_txwm) || (m_ven[5] && int'(rxl) > m_rxwm)));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        cmd_wr = 0; ovf = 0; udf = 0; acc = 0; eclr = 0; een_wr = 0;
        ven_wr = 0; wm_wr = 0; ack = 0;
        #1;
    endtask

    task automatic cmd(input int sp, input int dr, input int cs, input int ln);
        cmd_wr = 1; speed = 2'(sp); dir = 2'(dr); csid = CSID_W'(cs); len = LEN_W'(ln);
    endtask

    task automatic clear_all();
        eclr = 1; eclr_m = 6'h3f; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog expired actual=hung expected=finish");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        tick();
        // R12 reset state
        chk("R12 push", push, 0);
        chk("R12 status", status, 0);
        chk("R12 pend", pend, 0);
        chk("R12 err_irq", e_irq, 0);
        chk("R12 evt_irq", v_irq, 0);

        // R7 legal command, fields and csid carried
        keep = 1; cmd(2, 1, 3, 'h1a5); tick(); keep = 0;
        chk("R7 push", push, 1);
        chk("R7 csid", q_cs, 3);
        chk("R7 len", q_len, 'h1a5);
        chk("R7 speed", q_spd, 2);
        tick();
        chk("R7 single pulse", push, 0);
        cmd(0, 3, 2, 7); tick(); csid = 0;
        chk("R7 captured csid", q_cs, 2);

        // R1 busy
        ready = 0; cmd(0, 2, 0, 1); tick(); ready = 1;
        chk("R1 status", status, 'h01);
        chk("R1 no push", push, 0);
        chk("R8 reset enables", e_irq, 1);

        // R6 hold while flag pending
        cmd(0, 2, 1, 1); tick();
        chk("R6 no push", push, 0);
        chk("R6 status", status, 'h01);

        // R5 clear
        eclr = 1; eclr_m = 6'h01; tick();
        chk("R5 cleared", status, 0);

        // R2 invalid command
        cmd(3, 2, 0, 0); tick();
        chk("R2 rsvd speed", status, 'h08);
        chk("R2 no push", push, 0);
        clear_all();
        cmd(1, 3, 0, 0); tick();
        chk("R2 dual bidir", status, 'h08);
        clear_all();
        cmd(0, 3, 0, 0); tick();
        chk("R2 single bidir ok", push, 1);

        // R3 csid
        cmd(0, 2, 4, 0); tick();
        chk("R3 csid limit", status, 'h10);
        clear_all();
        cmd(3, 2, 255, 0); tick();
        chk("R3 both flags", status, 'h18);
        clear_all();

        // R4 overflow/underflow
        ovf = 1; udf = 1; tick();
        chk("R4 flags", status, 'h06);
        // R5 set wins over clear
        eclr = 1; eclr_m = 6'h02; ovf = 1; tick();
        chk("R5 set wins", status, 'h06);
        clear_all();

        // R8 enables and access flag
        een_wr = 1; een_d = 0; tick();
        ovf = 1; tick();
        chk("R8 masked", e_irq, 0);
        acc = 1; tick();
        chk("R4 access flag", status, 'h22);
        chk("R8 access unmasked", e_irq, 1);
        clear_all();
        een_wr = 1; een_d = 5'h1f; tick();
        udf = 1; tick();
        chk("R8 enabled", e_irq, 1);
        clear_all();

        // R9 watermarks
        ven_wr = 1; ven_d = 6'b100000; tick();
        rxl = 127; #1 chk("R9 rx wm reset 127", v_irq, 0);
        rxl = 128; #1 chk("R9 rx above", v_irq, 1);
        rxl = 0;
        ven_wr = 1; ven_d = 6'b010000; tick();
        chk("R9 tx wm reset 0", v_irq, 0);
        wm_wr = 1; txwm_d = 5; rxwm_d = 10; tick();
        txl = 4; #1 chk("R9 tx below", v_irq, 1);
        txl = 5; #1 chk("R9 tx equal", v_irq, 0);
        ven_wr = 1; ven_d = 6'b100000; tick();
        rxl = 11; #1 chk("R9 rx 11", v_irq, 1);
        rxl = 10; #1 chk("R9 rx equal", v_irq, 0);
        rxl = 0;

        // R10 / R11 edges
        ven_wr = 1; ven_d = 6'b001111; tick();
        active = 1; tick();
        active = 0; tick();
        chk("R10 idle edge", pend, 'h1);
        chk("R11 irq from edge", v_irq, 1);
        ready = 0; tick();
        ready = 1; tick();
        chk("R10 ready edge", pend, 'h3);
        txe = 1; tick();
        chk("R10 tx empty edge", pend, 'h7);
        rxf = 1; tick();
        chk("R10 rx full edge", pend, 'hf);
        ack = 1; ack_m = 4'hf; tick();
        chk("R10 ack", pend, 0);
        chk("R11 irq clear", v_irq, 0);
        rxf = 0; tick();
        rxf = 1; ack = 1; ack_m = 4'h8; tick();
        chk("R10 edge wins ack", pend, 'h8);
        ack = 1; ack_m = 4'h8; tick();
        chk("R10 ack again", pend, 0);
        ven_wr = 1; ven_d = 0; tick();
        txe = 0; tick();
        txe = 1; tick();
        chk("R10 disabled edge", pend, 0);

        tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule